// File: doc/BRIEF.md
# CAN Fault-Confinement and Reset Controller

This block keeps the fault-confinement standing of a CAN node (error active, error passive or bus off) together with its transmit and receive error counters. Error pulses from the protocol engine move the counters, and the counters decide the standing. Once the node is bus off, it stays there until software asks for recovery. After recovery, the node may talk again only after a run of recessive bits has been seen on the receive line.

The block also carries the software reset controls. A forced-reset bit takes the transmit pin recessive on the next cycle. It then asserts the protocol-unit reset a few clocks later, and that reset clears the counters and the timestamp. A timestamp-reset bit zeroes the 16-bit timestamp counter and reads back busy until the counter has been cleared. The timestamp counter advances on a prescaled bit-time strobe, and the prescaler can only be changed while the node is held in reset. Transmit and receive requests live outside this block and are never touched by it.

Top module: `can_fault_ctrl`

## Requirements
- R1: A write strobe on `rbo_wr` while `state` is bus off (2) raises `rbo_busy` after that edge. On the next edge, `tec` and `rec` become 0 and `state` becomes error active (0).
- R2: A write strobe on `rbo_wr` while `state` is not bus off leaves `rbo_busy` at 0 and leaves the counters and the state unchanged.
- R3: `rbo_busy` stays 1 until `state` has read error active for one cycle, then returns to 0 by itself.
- R4: After a bus-off recovery, `comm_en` stays 0 until 11 consecutive `bit_tick` samples of `rx_bit` equal to 1 have been taken. A sample of 0 restarts the run.
- R5: A write of 1 to the forced-reset bit (`frst_we` with `frst_wd`=1) sets `tx_force` after that edge. `pcu_rst` follows 3 cycles after `tx_force` rises, which is within 5 clocks of the write. Both fall in the same order after a write of 0.
- R6: While `pcu_rst` is 1, `tec`, `rec` and `tstamp` are cleared to 0 on every edge. This overrides any increment pulse in the same cycle.
- R7: `comm_en` is 1 only when the forced-reset bit is 0, `rst_bit` is 0, `pcu_rst` is 0, the node is not bus off and no recovery run is pending.
- R8: A strobe on `tsr_wr` raises `tsr_busy` after its edge. `tstamp` reads 0 after the next edge. `tsr_busy` drops once `tstamp` has been seen at 0.
- R9: `tsp` selects division of `bit_tick` by 1, 2, 4 or 8 for values 0 to 3. With division N, `tstamp` advances on every Nth tick after a clear. A `tsp_we` write takes effect only while the forced-reset bit or `rst_bit` is 1, and is otherwise ignored.
- R10: `state` reads error passive (1) when either counter is 128 or more. A `tec_inc` that would take `tec` past 255 saturates it at 255 and enters bus off (2). In bus off, counter pulses are ignored.
- R11: `tec_inc` adds 8, `tec_dec` subtracts 1, `rec_inc` adds 1 and `rec_dec` subtracts 1. No counter goes below 0, and `rec` stops at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rbo_wr | input | 1 | Write of 1 to the return-from-bus-off bit |
| frst_we | input | 1 | Write strobe of the forced-reset bit |
| frst_wd | input | 1 | Value written to the forced-reset bit |
| rst_bit | input | 1 | Ordinary reset bit level, held in another register |
| tsr_wr | input | 1 | Write of 1 to the timestamp-reset bit |
| tsp_we | input | 1 | Write strobe of the prescaler field |
| tsp_wd | input | 2 | Prescaler value written |
| rx_bit | input | 1 | Sampled receive bit (1 = recessive) |
| bit_tick | input | 1 | One-cycle bit-time strobe |
| tec_inc | input | 1 | Transmit error pulse (+8) |
| tec_dec | input | 1 | Transmit success pulse (-1) |
| rec_inc | input | 1 | Receive error pulse (+1) |
| rec_dec | input | 1 | Receive success pulse (-1) |
| state | output | 2 | 0 error active, 1 error passive, 2 bus off |
| tec | output | 8 | Transmit error counter |
| rec | output | 8 | Receive error counter |
| tstamp | output | 16 | Timestamp counter |
| tsp | output | 2 | Current prescaler selection |
| rbo_busy | output | 1 | Readback of the return-from-bus-off bit |
| tsr_busy | output | 1 | Readback of the timestamp-reset bit |
| tx_force | output | 1 | Forces the transmit pin recessive (high) |
| pcu_rst | output | 1 | Reset to the protocol unit |
| comm_en | output | 1 | Node allowed to take part in bus traffic |

## Verification
Two functions can hit the counters in the same cycle: the protocol-unit clear and an ordinary error pulse. The bench drives `rec_inc` during a cycle in which `pcu_rst` is already high. It passes only if `rec` still reads 0 afterwards, showing that the clear wins. A second collision happens at the bus-off boundary. There, `tec_inc` lands on a counter of 247 and then 255, and the bench expects saturation at 255, not wrap-around, together with the change to bus off.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

   typedef enum logic [1:0] {
      FC_ACTIVE  = 2'd0,
      FC_PASSIVE = 2'd1,
      FC_BUSOFF  = 2'd2
   } fc_state_t;

   function automatic fc_state_t fc_classify(input logic boff,
                                             input logic [7:0] tec_v,
                                             input logic [7:0] rec_v,
                                             input int unsigned lim);
      if (boff)
         return FC_BUSOFF;
      if (32'(tec_v) >= lim || 32'(rec_v) >= lim)
         return FC_PASSIVE;
      return FC_ACTIVE;
   endfunction

endpackage

// File: rtl/can_fc_errcnt.sv
module can_fc_errcnt
   import can_fc_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int TEC_STEP    = 8,
   parameter int PASSIVE_LIM = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             rbo_wr,
   input  logic             tec_inc,
   input  logic             tec_dec,
   input  logic             rec_inc,
   input  logic             rec_dec,
   output logic [CNT_W-1:0] tec,
   output logic [CNT_W-1:0] rec,
   output fc_state_t        state,
   output logic             rbo_busy,
   output logic             recov_start
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W:0]   STEP_X  = (CNT_W+1)'(TEC_STEP);

   logic [CNT_W-1:0] tec_n, rec_n;
   logic [CNT_W:0]   tec_sum;
   logic             boff_n, pend_n;
   fc_state_t        state_n;

   always_comb begin
      tec_n       = tec;
      rec_n       = rec;
      boff_n      = (state == FC_BUSOFF);
      recov_start = 1'b0;
      tec_sum     = {1'b0, tec} + STEP_X;
      if (clr) begin
         tec_n  = '0;
         rec_n  = '0;
         boff_n = 1'b0;
      end else if (rbo_busy && state == FC_BUSOFF) begin
         tec_n       = '0;
         rec_n       = '0;
         boff_n      = 1'b0;
         recov_start = 1'b1;
      end else if (state != FC_BUSOFF) begin
         if (tec_inc) begin
            if (tec_sum > {1'b0, CNT_MAX}) begin
               tec_n  = CNT_MAX;
               boff_n = 1'b1;
            end else begin
               tec_n = tec_sum[CNT_W-1:0];
            end
         end else if (tec_dec && tec != '0) begin
            tec_n = tec - 1'b1;
         end
         if (rec_inc) begin
            if (rec != CNT_MAX)
               rec_n = rec + 1'b1;
         end else if (rec_dec && rec != '0) begin
            rec_n = rec - 1'b1;
         end
      end
      state_n = fc_classify(boff_n, 8'(tec_n), 8'(rec_n), PASSIVE_LIM);
   end

   always_comb begin
      pend_n = rbo_busy;
      if (clr)
         pend_n = 1'b0;
      else if (rbo_wr && state == FC_BUSOFF)
         pend_n = 1'b1;
      else if (state == FC_ACTIVE)
         pend_n = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tec      <= '0;
         rec      <= '0;
         state    <= FC_ACTIVE;
         rbo_busy <= 1'b0;
      end else begin
         tec      <= tec_n;
         rec      <= rec_n;
         state    <= state_n;
         rbo_busy <= pend_n;
      end
   end
endmodule

// File: rtl/can_fc_idle_mon.sv
module can_fc_idle_mon #(
   parameter int IDLE_BITS = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic recov_start,
   input  logic bit_tick,
   input  logic rx_bit,
   output logic recov_wait
);
   localparam int RUN_W = $clog2(IDLE_BITS + 1);
   localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(IDLE_BITS - 1);

   logic [RUN_W-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         recov_wait <= 1'b0;
         run_q      <= '0;
      end else if (clr) begin
         recov_wait <= 1'b0;
         run_q      <= '0;
      end else if (recov_start) begin
         recov_wait <= 1'b1;
         run_q      <= '0;
      end else if (recov_wait && bit_tick) begin
         if (!rx_bit) begin
            run_q <= '0;
         end else if (run_q == RUN_LAST) begin
            recov_wait <= 1'b0;
            run_q      <= '0;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/can_fc_tstamp.sv
module can_fc_tstamp #(
   parameter int TS_W  = 16,
   parameter int TSP_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             cfg_open,
   input  logic             tsr_wr,
   input  logic             tsp_we,
   input  logic [TSP_W-1:0] tsp_wd,
   input  logic             bit_tick,
   output logic [TS_W-1:0]  tstamp,
   output logic [TSP_W-1:0] tsp,
   output logic             tsr_busy
);
   localparam int DIV_W = (1 << TSP_W) - 1;

   logic [DIV_W-1:0] div_q, mask;
   logic             adv;

   assign mask = DIV_W'((1 << tsp) - 1);
   assign adv  = bit_tick && ((div_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tsp <= '0;
      else if (tsp_we && cfg_open)
         tsp <= tsp_wd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tsr_busy <= 1'b0;
      else if (clr)
         tsr_busy <= 1'b0;
      else if (tsr_wr)
         tsr_busy <= 1'b1;
      else if (tsr_busy && tstamp == '0)
         tsr_busy <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tstamp <= '0;
         div_q  <= '0;
      end else if (clr || tsr_busy) begin
         tstamp <= '0;
         div_q  <= '0;
      end else if (bit_tick) begin
         div_q <= div_q + 1'b1;
         if (adv)
            tstamp <= tstamp + 1'b1;
      end
   end
endmodule

// File: rtl/can_fc_rstseq.sv
module can_fc_rstseq #(
   parameter int RST_LAT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frst_we,
   input  logic frst_wd,
   output logic frst_q,
   output logic pcu_rst
);
   logic [RST_LAT-1:0] dly_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         frst_q <= 1'b0;
      else if (frst_we)
         frst_q <= frst_wd;
   end

   generate
      for (genvar i = 0; i < RST_LAT; i++) begin : g_dly
         if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) dly_q[0] <= 1'b0;
               else        dly_q[0] <= frst_q;
            end
         end else begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) dly_q[i] <= 1'b0;
               else        dly_q[i] <= dly_q[i-1];
            end
         end
      end
   endgenerate

   assign pcu_rst = dly_q[RST_LAT-1];
endmodule

// File: rtl/can_fault_ctrl.sv
module can_fault_ctrl
   import can_fc_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int TS_W        = 16,
   parameter int TSP_W       = 2,
   parameter int TEC_STEP    = 8,
   parameter int PASSIVE_LIM = 128,
   parameter int IDLE_BITS   = 11,
   parameter int RST_LAT     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rbo_wr,
   input  logic              frst_we,
   input  logic              frst_wd,
   input  logic              rst_bit,
   input  logic              tsr_wr,
   input  logic              tsp_we,
   input  logic [TSP_W-1:0]  tsp_wd,
   input  logic              rx_bit,
   input  logic              bit_tick,
   input  logic              tec_inc,
   input  logic              tec_dec,
   input  logic              rec_inc,
   input  logic              rec_dec,
   output logic [1:0]        state,
   output logic [CNT_W-1:0]  tec,
   output logic [CNT_W-1:0]  rec,
   output logic [TS_W-1:0]   tstamp,
   output logic [TSP_W-1:0]  tsp,
   output logic              rbo_busy,
   output logic              tsr_busy,
   output logic              tx_force,
   output logic              pcu_rst,
   output logic              comm_en
);
   generate
      if (RST_LAT < 1 || RST_LAT > 4)
         $error("RST_LAT must keep the reset within 5 clocks of the write");
      if (CNT_W != 8)
         $error("error counters are 8 bits wide");
      if (IDLE_BITS < 2)
         $error("IDLE_BITS must be at least 2");
      if (TSP_W < 1 || TSP_W > 3)
         $error("TSP_W out of range");
      if (PASSIVE_LIM < 1 || PASSIVE_LIM > 255)
         $error("PASSIVE_LIM must fit the counter");
   endgenerate

   fc_state_t st;
   logic      frst_q, recov_start, recov_wait;

   can_fc_rstseq #(.RST_LAT(RST_LAT)) u_rstseq (
      .clk     (clk),
      .rst_n   (rst_n),
      .frst_we (frst_we),
      .frst_wd (frst_wd),
      .frst_q  (frst_q),
      .pcu_rst (pcu_rst)
   );

   can_fc_errcnt #(
      .CNT_W(CNT_W), .TEC_STEP(TEC_STEP), .PASSIVE_LIM(PASSIVE_LIM)
   ) u_errcnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (pcu_rst),
      .rbo_wr      (rbo_wr),
      .tec_inc     (tec_inc),
      .tec_dec     (tec_dec),
      .rec_inc     (rec_inc),
      .rec_dec     (rec_dec),
      .tec         (tec),
      .rec         (rec),
      .state       (st),
      .rbo_busy    (rbo_busy),
      .recov_start (recov_start)
   );

   can_fc_idle_mon #(.IDLE_BITS(IDLE_BITS)) u_idle (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (pcu_rst),
      .recov_start (recov_start),
      .bit_tick    (bit_tick),
      .rx_bit      (rx_bit),
      .recov_wait  (recov_wait)
   );

   can_fc_tstamp #(.TS_W(TS_W), .TSP_W(TSP_W)) u_tstamp (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (pcu_rst),
      .cfg_open (frst_q | rst_bit),
      .tsr_wr   (tsr_wr),
      .tsp_we   (tsp_we),
      .tsp_wd   (tsp_wd),
      .bit_tick (bit_tick),
      .tstamp   (tstamp),
      .tsp      (tsp),
      .tsr_busy (tsr_busy)
   );

   assign state    = st;
   assign tx_force = frst_q;
   assign comm_en  = !frst_q && !rst_bit && !pcu_rst && !recov_wait &&
                     (st != FC_BUSOFF);
endmodule

// File: rtl/can_fault_ctrl_chk.sv
module can_fault_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rbo_wr,
   input logic       frst_we,
   input logic       frst_wd,
   input logic       rst_bit,
   input logic       tsp_we,
   input logic [1:0] state,
   input logic [7:0] tec,
   input logic [7:0] rec,
   input logic [15:0] tstamp,
   input logic [1:0] tsp,
   input logic       rbo_busy,
   input logic       tx_force,
   input logic       pcu_rst,
   input logic       comm_en
);
   p_recover_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rbo_busy && state == 2'd2 && !pcu_rst) |=> (state == 2'd0 && tec == 8'd0 && rec == 8'd0));

   p_rbo_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rbo_wr && state != 2'd2 && !rbo_busy) |=> !rbo_busy);

   p_txpin_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (frst_we && frst_wd) |=> tx_force);

   p_pcu_in_time_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_force && $past(tx_force) && $past(tx_force, 2) && $past(tx_force, 3) &&
       $past(tx_force, 4)) |-> pcu_rst);

   p_reset_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pcu_rst |=> (tec == 8'd0 && rec == 8'd0 && tstamp == 16'd0));

   p_comm_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      comm_en |-> (!tx_force && !rst_bit && !pcu_rst && state != 2'd2));

   p_tsp_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tsp_we && !tx_force && !rst_bit) |=> $stable(tsp));

   p_busoff_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd2) |-> (tec == 8'hFF));

   p_passive_lim_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd1) |-> (tec >= 8'd128 || rec >= 8'd128));
endmodule

bind can_fault_ctrl can_fault_ctrl_chk chk_i (.*);

// File: tb/can_fault_ctrl_tb_top.sv
module can_fault_ctrl_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rbo_wr = 0, frst_we = 0, frst_wd = 0, rst_bit = 0, tsr_wr = 0, tsp_we = 0;
   logic [1:0] tsp_wd = 0;
   logic rx_bit = 1, bit_tick = 0, tec_inc = 0, tec_dec = 0, rec_inc = 0, rec_dec = 0;
   logic [1:0]  state, tsp;
   logic [7:0]  tec, rec;
   logic [15:0] tstamp;
   logic rbo_busy, tsr_busy, tx_force, pcu_rst, comm_en;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   can_fault_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .rbo_wr(rbo_wr), .frst_we(frst_we), .frst_wd(frst_wd),
      .rst_bit(rst_bit), .tsr_wr(tsr_wr), .tsp_we(tsp_we), .tsp_wd(tsp_wd),
      .rx_bit(rx_bit), .bit_tick(bit_tick), .tec_inc(tec_inc), .tec_dec(tec_dec),
      .rec_inc(rec_inc), .rec_dec(rec_dec), .state(state), .tec(tec), .rec(rec),
      .tstamp(tstamp), .tsp(tsp), .rbo_busy(rbo_busy), .tsr_busy(tsr_busy),
      .tx_force(tx_force), .pcu_rst(pcu_rst), .comm_en(comm_en)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_n(ref logic sig, input int n);
      @(negedge clk); sig = 1'b1;
      step(n);
      sig = 1'b0;
   endtask

   task automatic bit_in(input logic v);
      @(negedge clk); rx_bit = v; bit_tick = 1'b1;
      @(negedge clk); bit_tick = 1'b0;
   endtask

   task automatic t_reset_state();
      chk("R11 reset state", state, 0);
      chk("R11 reset tec", tec, 0);
      chk("R11 reset rec", rec, 0);
      chk("R6 reset tstamp", tstamp, 0);
      chk("R5 reset tx_force", tx_force, 0);
      chk("R7 reset comm_en", comm_en, 1);
   endtask

   task automatic t_rec_passive();
      pulse_n(rec_inc, 127);
      chk("R10 rec 127", rec, 127);
      chk("R10 still active", state, 0);
      pulse_n(rec_inc, 1);
      chk("R10 passive at 128", state, 1);
      pulse_n(rec_dec, 1);
      chk("R11 rec dec", rec, 127);
      chk("R10 back active", state, 0);
      pulse_n(rec_dec, 130);
      chk("R11 rec floor", rec, 0);
   endtask

   task automatic t_rbo_ignored();
      pulse_n(tec_inc, 1);
      chk("R11 tec step", tec, 8);
      pulse_n(rbo_wr, 1);
      chk("R2 busy stays 0", rbo_busy, 0);
      step(1);
      chk("R2 tec kept", tec, 8);
      chk("R2 state kept", state, 0);
   endtask

   task automatic t_busoff();
      pulse_n(tec_inc, 30);
      chk("R10 tec 248", tec, 248);
      chk("R10 tec passive", state, 1);
      pulse_n(tec_dec, 1);
      chk("R11 tec dec", tec, 247);
      pulse_n(tec_inc, 1);
      chk("R10 tec 255 exact", tec, 255);
      chk("R10 not yet bus off", state, 1);
      pulse_n(tec_inc, 1);
      chk("R10 saturate", tec, 255);
      chk("R10 bus off", state, 2);
      pulse_n(tec_dec, 1);
      pulse_n(rec_inc, 1);
      chk("R10 frozen tec", tec, 255);
      chk("R10 frozen rec", rec, 0);
      chk("R7 no comm in bus off", comm_en, 0);
   endtask

   task automatic t_recover();
      pulse_n(rbo_wr, 1);
      chk("R1 busy set", rbo_busy, 1);
      chk("R1 still bus off", state, 2);
      step(1);
      chk("R1 state active", state, 0);
      chk("R1 tec cleared", tec, 0);
      chk("R3 busy held", rbo_busy, 1);
      step(1);
      chk("R3 busy cleared", rbo_busy, 0);
      chk("R4 waiting", comm_en, 0);
   endtask

   task automatic t_idle_run();
      for (int i = 0; i < 10; i++) bit_in(1'b1);
      chk("R4 10 recessive not enough", comm_en, 0);
      bit_in(1'b0);
      for (int i = 0; i < 10; i++) bit_in(1'b1);
      chk("R4 run restarted", comm_en, 0);
      bit_in(1'b1);
      chk("R4 11 recessive", comm_en, 1);
   endtask

   task automatic t_tstamp();
      @(negedge clk); tsp_we = 1; tsp_wd = 2'd2;
      @(negedge clk); tsp_we = 0;
      chk("R9 write ignored while operating", tsp, 0);
      rst_bit = 1'b1;
      @(negedge clk); tsp_we = 1; tsp_wd = 2'd2;
      @(negedge clk); tsp_we = 0;
      chk("R9 write accepted in reset", tsp, 2);
      chk("R7 rst_bit blocks comm", comm_en, 0);
      pulse_n(tsr_wr, 1);
      chk("R8 tsr busy", tsr_busy, 1);
      step(1);
      chk("R8 tstamp zero", tstamp, 0);
      step(1);
      chk("R8 tsr self clear", tsr_busy, 0);
      for (int i = 0; i < 7; i++) bit_in(1'b1);
      chk("R9 div4 after 7", tstamp, 1);
      bit_in(1'b1);
      chk("R9 div4 after 8", tstamp, 2);
      @(negedge clk); tsp_we = 1; tsp_wd = 2'd3;
      @(negedge clk); tsp_we = 0;
      pulse_n(tsr_wr, 1);
      step(2);
      for (int i = 0; i < 15; i++) bit_in(1'b1);
      chk("R9 div8 after 15", tstamp, 1);
      @(negedge clk); tsp_we = 1; tsp_wd = 2'd0;
      @(negedge clk); tsp_we = 0;
      for (int i = 0; i < 3; i++) bit_in(1'b1);
      chk("R9 div1", tstamp, 4);
      rst_bit = 1'b0;
   endtask

   task automatic t_forced_reset();
      pulse_n(rec_inc, 3);
      pulse_n(tec_inc, 1);
      chk("R11 pre rec", rec, 3);
      @(negedge clk); frst_we = 1; frst_wd = 1;
      @(negedge clk); frst_we = 0;
      chk("R5 tx_force next", tx_force, 1);
      chk("R5 pcu not yet", pcu_rst, 0);
      chk("R7 frst blocks comm", comm_en, 0);
      step(2);
      chk("R5 pcu still low", pcu_rst, 0);
      step(1);
      chk("R5 pcu asserted", pcu_rst, 1);
      rec_inc = 1'b1;
      @(negedge clk); rec_inc = 1'b0;
      chk("R6 rec cleared despite inc", rec, 0);
      chk("R6 tec cleared", tec, 0);
      chk("R6 tstamp cleared", tstamp, 0);
      @(negedge clk); frst_we = 1; frst_wd = 0;
      @(negedge clk); frst_we = 0;
      chk("R5 tx_force released", tx_force, 0);
      chk("R7 pcu still blocks", comm_en, 0);
      step(3);
      chk("R5 pcu released", pcu_rst, 0);
      chk("R7 comm resumes", comm_en, 1);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      t_reset_state();
      t_rec_passive();
      t_rbo_ignored();
      t_busoff();
      t_recover();
      t_idle_run();
      t_tstamp();
      t_forced_reset();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule